// File: doc/BRIEF.md
# Event-Driven GPIO Output Action Unit

This block holds the output register of one group of 32 general-purpose pins and lets hardware events change single bits of it with no processor involved. Four event channels are each configured by one byte of a 32-bit control word. A channel names a target pin and one of four actions. When the channel is enabled and its one-cycle strobe arrives, the action lands on the target bit at the next clock edge. The action either loads the event's level into the bit, forces it high, forces it low, or inverts it.

Software reaches the output register and the control word through a small register port with a write strobe, a word address, write data and a combinational read path. The control word can be locked by a write-protect input. Channel conflicts are settled by channel number. A hardware event on a bit wins over a processor write to the same bit in the same cycle.

Top module: `gpio_evt_out`

## Requirements
- R1: After reset, `pin_out` is all zeros and the control word reads as all zeros, so every channel is disabled.
- R2: Channel c is configured by control bits [8c+7:8c]. Within that byte, bit 7 enables the channel, bits 6:5 hold the action code and bits 4:0 select the target pin (0 to 31). The control word reads back exactly as written.
- R3: A strobe on a channel whose enable bit is 0 leaves `pin_out` unchanged.
- R4: Action code 0 loads the channel's `evt_level` bit into the target output bit on the clock edge that samples the strobe.
- R5: Action code 1 sets the target output bit to 1.
- R6: Action code 2 clears the target output bit to 0.
- R7: Action code 3 inverts the target output bit from the value it held before the edge.
- R8: A control-word write made while `reg_wprot` is 1 is ignored. Writes to the output register are not affected by `reg_wprot`.
- R9: When several enabled channels that receive a strobe name the same pin in one cycle, the action of the highest-numbered one decides that bit.
- R10: A processor write to the output register in the same cycle as an event action writes every bit except the event-targeted bit, which takes the event result. A toggle works on the bit value from before the write.
- R11: Word address 0 reads and writes the output register. Word address 1 reads and writes the control word. Other addresses read as zero, and writes to them change nothing.
- R12: With no enabled strobe and no output-register write, `pin_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_wprot | input | 1 | Write protect for the control word |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_strobe | input | 4 | One-cycle event pulse, one bit per channel |
| evt_level | input | 4 | Event level per channel, used only by action 0 |
| pin_out | output | 32 | Output register contents |

## Verification
The hardest case to reach is a collision: up to four channels aimed at one pin, combined with a processor write to that same register in the same edge. The result then depends on channel priority and on whether the toggle reads the bit from before the write. To reach it, the stimulus points all four channels at one pin with four different actions. It fires all sixteen strobe subsets at several pins, and then repeats chosen collisions together with output writes of contrasting data. A separate sweep goes through every channel, every action code and every pin. The other channel bytes hold disabled settings that would be destructive if they were ever obeyed.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  // Action codes for one event channel
  typedef enum logic [1:0] {
    ACT_LOAD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } evt_act_e;

  // Fixed layout of one channel configuration byte
  localparam int CFG_W      = 8;
  localparam int CFG_EN_BIT = 7;
  localparam int CFG_ACT_LO = 5;
  localparam int CFG_PID_W  = 5;

  // Word addresses on the register port
  localparam logic [1:0] ADDR_OUT = 2'd0;
  localparam logic [1:0] ADDR_CFG = 2'd1;

endpackage

// File: rtl/gpio_evt_cfg_reg.sv
module gpio_evt_cfg_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              wprot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_q
);

  logic              cfg_en;
  logic [DATA_W-1:0] cfg_d;

  // Next-state: a write lands only when it is not locked
  always_comb begin
    cfg_en = wr_sel && !wprot;
    cfg_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/gpio_evt_chan.sv
module gpio_evt_chan
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [CFG_W-1:0]    cfg_byte,
  input  logic                strobe,
  input  logic                level,
  input  logic [NUM_PINS-1:0] cur_q,
  output logic [NUM_PINS-1:0] tgt_mask,
  output logic                tgt_val
);

  localparam int PID_W = $clog2(NUM_PINS);

  logic           ch_en;
  evt_act_e       ch_act;
  logic [PID_W-1:0] ch_pid;
  logic           fire;
  logic           cur_bit;

  always_comb begin
    ch_en   = cfg_byte[CFG_EN_BIT];
    ch_act  = evt_act_e'(cfg_byte[CFG_ACT_LO +: 2]);
    ch_pid  = cfg_byte[PID_W-1:0];
    fire    = ch_en && strobe;
    cur_bit = cur_q[ch_pid];

    tgt_mask = '0;
    if (fire) begin
      tgt_mask[ch_pid] = 1'b1;
    end

    unique case (ch_act)
      ACT_LOAD: tgt_val = level;
      ACT_SET:  tgt_val = 1'b1;
      ACT_CLR:  tgt_val = 1'b0;
      ACT_TGL:  tgt_val = ~cur_bit;
      default:  tgt_val = cur_bit;
    endcase
  end

endmodule

// File: rtl/gpio_evt_out_reg.sv
module gpio_evt_out_reg #(
  parameter int NUM_PINS = 32,
  parameter int NUM_CH   = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_sel,
  input  logic [NUM_PINS-1:0]               wdata,
  input  logic [NUM_CH-1:0][NUM_PINS-1:0]   tgt_mask,
  input  logic [NUM_CH-1:0]                 tgt_val,
  output logic [NUM_PINS-1:0]               out_q
);

  logic [NUM_PINS-1:0] out_d;
  logic                out_en;

  // Processor data first, then channels in rising order, so the
  // highest-numbered channel has the last word on its bit.
  always_comb begin
    out_d  = wr_sel ? wdata : out_q;
    out_en = wr_sel;
    for (int c = 0; c < NUM_CH; c++) begin
      out_d  = (out_d & ~tgt_mask[c]) | ({NUM_PINS{tgt_val[c]}} & tgt_mask[c]);
      out_en = out_en | (|tgt_mask[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

endmodule

// File: rtl/gpio_evt_out.sv
module gpio_evt_out
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr_en,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [NUM_CH*CFG_W-1:0]  reg_wdata,
  input  logic                     reg_wprot,
  output logic [NUM_CH*CFG_W-1:0]  reg_rdata,
  input  logic [NUM_CH-1:0]        evt_strobe,
  input  logic [NUM_CH-1:0]        evt_level,
  output logic [NUM_PINS-1:0]      pin_out
);

  localparam int DATA_W = NUM_CH * CFG_W;

  logic                            wr_out;
  logic                            wr_cfg;
  logic [DATA_W-1:0]               cfg_q;
  logic [NUM_PINS-1:0]             out_q;
  logic [NUM_CH-1:0][NUM_PINS-1:0] tgt_mask;
  logic [NUM_CH-1:0]               tgt_val;
  logic [DATA_W-1:0]               out_rd;

  always_comb begin
    wr_out = reg_wr_en && (reg_addr == ADDR_W'(ADDR_OUT));
    wr_cfg = reg_wr_en && (reg_addr == ADDR_W'(ADDR_CFG));
  end

  gpio_evt_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_sel(wr_cfg),
    .wprot (reg_wprot),
    .wdata (reg_wdata),
    .cfg_q (cfg_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gpio_evt_chan #(.NUM_PINS(NUM_PINS)) u_chan (
      .cfg_byte(cfg_q[c*CFG_W +: CFG_W]),
      .strobe  (evt_strobe[c]),
      .level   (evt_level[c]),
      .cur_q   (out_q),
      .tgt_mask(tgt_mask[c]),
      .tgt_val (tgt_val[c])
    );
  end

  gpio_evt_out_reg #(.NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_out),
    .wdata   (reg_wdata[NUM_PINS-1:0]),
    .tgt_mask(tgt_mask),
    .tgt_val (tgt_val),
    .out_q   (out_q)
  );

  // Read path
  always_comb begin
    out_rd = '0;
    out_rd[NUM_PINS-1:0] = out_q;
    if (reg_addr == ADDR_W'(ADDR_OUT)) begin
      reg_rdata = out_rd;
    end else if (reg_addr == ADDR_W'(ADDR_CFG)) begin
      reg_rdata = cfg_q;
    end else begin
      reg_rdata = '0;
    end
  end

  assign pin_out = out_q;

endmodule

// File: rtl/gpio_evt_out_chk.sv
module gpio_evt_out_chk
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr_en,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic                     reg_wprot,
  input logic [NUM_CH-1:0]        evt_strobe,
  input logic [NUM_CH-1:0]        evt_level,
  input logic [NUM_PINS-1:0]      pin_out,
  input logic [NUM_CH*CFG_W-1:0]  cfg_q
);

  localparam int TOP   = NUM_CH - 1;
  localparam int PID_W = $clog2(NUM_PINS);

  logic [CFG_W-1:0] top_cfg;
  logic [PID_W-1:0] top_pid;
  logic             top_fire;
  logic [NUM_CH-1:0] en_vec;

  always_comb begin
    top_cfg  = cfg_q[TOP*CFG_W +: CFG_W];
    top_pid  = top_cfg[PID_W-1:0];
    top_fire = top_cfg[CFG_EN_BIT] && evt_strobe[TOP];
    for (int c = 0; c < NUM_CH; c++) begin
      en_vec[c] = cfg_q[c*CFG_W + CFG_EN_BIT];
    end
  end

  // R4: highest channel loading its level always decides its bit
  a_r4_load_level: assert property (@(posedge clk) disable iff (!rst_n)
    top_fire && top_cfg[CFG_ACT_LO +: 2] == ACT_LOAD
    |=> pin_out[$past(top_pid)] == $past(evt_level[TOP]));

  // R5
  a_r5_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    top_fire && top_cfg[CFG_ACT_LO +: 2] == ACT_SET
    |=> pin_out[$past(top_pid)] == 1'b1);

  // R6
  a_r6_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    top_fire && top_cfg[CFG_ACT_LO +: 2] == ACT_CLR
    |=> pin_out[$past(top_pid)] == 1'b0);

  // R7
  a_r7_toggle_bit: assert property (@(posedge clk) disable iff (!rst_n)
    top_fire && top_cfg[CFG_ACT_LO +: 2] == ACT_TGL
    |=> pin_out[$past(top_pid)] != $past(pin_out[top_pid]));

  // R8
  a_r8_locked_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && reg_wprot |=> $stable(cfg_q));

  // R12 (covers R3 as well: disabled strobes do not count)
  a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(evt_strobe & en_vec)) && !(reg_wr_en && reg_addr == ADDR_W'(ADDR_OUT))
    |=> $stable(pin_out));

endmodule

bind gpio_evt_out gpio_evt_out_chk #(
  .NUM_PINS(NUM_PINS),
  .NUM_CH  (NUM_CH),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wprot (reg_wprot),
  .evt_strobe(evt_strobe),
  .evt_level (evt_level),
  .pin_out   (pin_out),
  .cfg_q     (cfg_q)
);

// File: tb/sim_gpio_evt_out.sv
`timescale 1ns/1ps
module sim_gpio_evt_out;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_wprot;
  logic [31:0] reg_rdata;
  logic [3:0]  evt_strobe;
  logic [3:0]  evt_level;
  logic [31:0] pin_out;

  always #2 clk = ~clk;

  gpio_evt_out u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wprot(reg_wprot), .reg_rdata(reg_rdata),
    .evt_strobe(evt_strobe), .evt_level(evt_level), .pin_out(pin_out)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] m_out;
  logic [31:0] m_cfg;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock of stimulus; the model advances per the requirements
  task automatic step(input bit wr, input logic [1:0] a, input logic [31:0] d,
                      input bit wp, input logic [3:0] s, input logic [3:0] l);
    logic [31:0] nx;
    logic [7:0]  b;
    nx = (wr && a == 2'd0) ? d : m_out;
    for (int c = 0; c < 4; c++) begin
      b = m_cfg[8*c +: 8];
      if (s[c] && b[7]) begin
        case (b[6:5])
          2'd0: nx[b[4:0]] = l[c];
          2'd1: nx[b[4:0]] = 1'b1;
          2'd2: nx[b[4:0]] = 1'b0;
          default: nx[b[4:0]] = ~m_out[b[4:0]];
        endcase
      end
    end
    if (wr && a == 2'd1 && !wp) m_cfg = d;
    m_out = nx;
    reg_wr_en = wr; reg_addr = a; reg_wdata = d; reg_wprot = wp;
    evt_strobe = s; evt_level = l;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wprot = 1'b0; evt_strobe = '0; evt_level = '0;
    reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic rdchk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  function automatic string act_tag(input int a);
    case (a)
      0: return "R4 load";
      1: return "R5 set";
      2: return "R6 clear";
      default: return "R7 toggle";
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pat;
    logic [31:0] cfg;
    logic [3:0]  lvl;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    reg_wprot = 1'b0; evt_strobe = '0; evt_level = '0;
    m_out = '0; m_cfg = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset pin_out", pin_out, 32'h0);
    rdchk("R1 reset control", 2'd1, 32'h0);
    rdchk("R1 reset out readback", 2'd0, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: all channels disabled after reset
    step(1'b1, 2'd0, 32'h1234_5678, 1'b0, 4'h0, 4'h0);
    step(1'b0, 2'd0, 32'h0, 1'b0, 4'hF, 4'hF);
    chk("R3 disabled channels", pin_out, m_out);

    // R2..R7 sweep: every channel, action and pin; others disabled but armed
    for (int c = 0; c < 4; c++) begin
      for (int a = 0; a < 4; a++) begin
        for (int p = 0; p < 32; p++) begin
          pat = 32'hA53C_96E1 ^ (32'h0101_0101 * p);
          cfg = '0;
          for (int o = 0; o < 4; o++) begin
            if (o == c) cfg[8*o +: 8] = {1'b1, 2'(a), 5'(p)};
            else        cfg[8*o +: 8] = {1'b0, 2'(3 - a), 5'(31 - p)};
          end
          lvl = 4'(p) ^ 4'(c) ^ 4'(a);
          step(1'b1, 2'd0, pat, 1'b0, 4'h0, 4'h0);
          step(1'b1, 2'd1, cfg, 1'b0, 4'h0, 4'h0);
          rdchk("R2 control readback", 2'd1, m_cfg);
          step(1'b0, 2'd0, 32'h0, 1'b0, 4'hF, lvl);
          chk(act_tag(a), pin_out, m_out);
        end
      end
    end

    // R8: locked control word, unlocked output register
    step(1'b1, 2'd1, 32'h00A3_0000, 1'b0, 4'h0, 4'h0);
    step(1'b1, 2'd1, 32'hFFFF_FFFF, 1'b1, 4'h0, 4'h0);
    rdchk("R8 locked control", 2'd1, 32'h00A3_0000);
    step(1'b1, 2'd0, 32'h0F0F_0F0F, 1'b1, 4'h0, 4'h0);
    chk("R8 output write under lock", pin_out, 32'h0F0F_0F0F);
    step(1'b0, 2'd0, 32'h0, 1'b1, 4'h4, 4'h0);
    chk("R8 old config still active", pin_out, m_out);

    // R9: four channels on one pin, all strobe subsets
    foreach (pat[i]) begin end
    for (int k = 0; k < 3; k++) begin
      int p;
      p = (k == 0) ? 0 : (k == 1) ? 13 : 31;
      cfg = {1'b1, 2'd0, 5'(p), 1'b1, 2'd3, 5'(p), 1'b1, 2'd2, 5'(p), 1'b1, 2'd1, 5'(p)};
      step(1'b1, 2'd1, cfg, 1'b0, 4'h0, 4'h0);
      for (int m = 0; m < 16; m++) begin
        step(1'b1, 2'd0, (m[0] ? 32'hFFFF_FFFF : 32'h0) ^ (32'h1 << m), 1'b0, 4'h0, 4'h0);
        step(1'b0, 2'd0, 32'h0, 1'b0, 4'(m), m[1] ? 4'h0 : 4'hF);
        chk("R9 highest channel wins", pin_out, m_out);
      end
    end

    // R10: event beats the processor write on its own bit only
    step(1'b1, 2'd1, {8'h00, 1'b1, 2'd3, 5'd20, 1'b1, 2'd2, 5'd9, 1'b1, 2'd1, 5'd3},
         1'b0, 4'h0, 4'h0);
    for (int w = 0; w < 3; w++) begin
      logic [31:0] wd;
      wd = (w == 0) ? 32'h0 : (w == 1) ? 32'hFFFF_FFFF : 32'h5555_AAAA;
      step(1'b1, 2'd0, ~wd, 1'b0, 4'h0, 4'h0);
      step(1'b1, 2'd0, wd, 1'b0, 4'h7, 4'h0);
      chk("R10 event beats write", pin_out, m_out);
    end

    // R11: unused addresses
    step(1'b1, 2'd2, 32'hDEAD_BEEF, 1'b0, 4'h0, 4'h0);
    step(1'b1, 2'd3, 32'hCAFE_F00D, 1'b0, 4'h0, 4'h0);
    rdchk("R11 addr2 reads zero", 2'd2, 32'h0);
    rdchk("R11 addr3 reads zero", 2'd3, 32'h0);
    rdchk("R11 control untouched", 2'd1, m_cfg);
    rdchk("R11 output readback", 2'd0, m_out);
    chk("R11 pin_out untouched", pin_out, m_out);

    // R12: idle cycles hold
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 2'd0, 32'h0, 1'b0, 4'h8, 4'hF);
      chk("R12 hold when idle", pin_out, m_out);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule